// File: doc/BRIEF.md
# Scanline-Scheduled Palette Loader

This block holds the colour palette of a raster display: sixteen entries of eight bits each. The pixel path looks an entry up by colour index through a combinational read port. Software can set any entry directly with a register write. It can also schedule a whole batch of colour changes for a chosen scanline, which removes the need for a timed interrupt routine.

To schedule a batch, software writes three registers: the base address of a byte list in memory, the number of entries, and the target scanline. Writing the scanline register arms the request. The block then fetches the bytes over a request/acknowledge read port into an internal buffer. At the start of the target line, while the display is in horizontal blanking, it copies the whole buffer into the palette in a single clock edge. No visible line therefore shows a mix of old and new colours. A pending flag stays high from arming until the copy happens.

Top module: `palListLoader`

## Requirements
- R1: After reset, all sixteen palette entries read 0, `listPending` is 0 and `memReq` is 0.
- R2: A write to register address 0..7 sets colour 0..7, and a write to address 8..15 sets colour 8..15. The value written is `regWrData[7:0]`. `pixColour` shows entry `pixIdx` from the cycle after the write.
- R3: Register address 16 holds the list base address, 17 holds the list length and 18 holds the target line. A write to address 18 raises `listPending` on the next cycle.
- R4: List entry i is read from address base+i, in increasing order, one byte per acknowledged request. `memReq` stays high with `memAddr` unchanged until `memAck`, and `memData` is captured in the cycle where `memAck` is high.
- R5: A length above 16 is clipped to 16, so exactly min(length,16) reads are made.
- R6: The fetched bytes do not reach the palette before the target line. A `lineStart` pulse whose `lineNum` differs from the target changes nothing.
- R7: On a `lineStart` cycle whose `lineNum` equals the target, with the fetch complete, list entry i replaces colour i for every i below the clipped length. The other entries keep their values, and `listPending` clears on the same edge.
- R8: If the target line arrives before the fetch has completed, nothing is applied and `listPending` stays high. The list is applied on a later matching line once the fetch is complete.
- R9: Writing address 18 while a list is pending cancels that list. The fetch restarts from the current base and length registers, and the cancelled list is never applied.
- R10: A length of 0 makes no memory reads. At the target line, `listPending` clears and the palette is unchanged.
- R11: `memReq` is only ever high while `listPending` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address (0..15 colours, 16 base, 17 length, 18 target line) |
| regWrData | input | 16 | Register write data |
| lineStart | input | 1 | One-cycle pulse at the start of each scanline (horizontal blanking) |
| lineNum | input | 9 | Number of the scanline that is starting |
| memReq | output | 1 | Memory read request |
| memAddr | output | 16 | Memory read address |
| memAck | input | 1 | Memory acknowledge; data valid in this cycle |
| memData | input | 8 | Memory read data |
| pixIdx | input | 4 | Colour index from the pixel path |
| pixColour | output | 8 | Palette entry selected by `pixIdx` |
| listPending | output | 1 | A scheduled list has not yet been applied |

## Verification
The bench builds the block with its default parameters: sixteen entries, 16-bit memory addresses and 9-bit line numbers. With these values, a requested length of 40 exercises the clip at exactly sixteen reads and the write to the final palette entry. The memory model answers every other cycle and can be stalled at will. This makes the late-line case and a cancellation during an outstanding request deterministic.

// File: rtl/palPkg.sv
package palPkg;

  typedef struct packed {
    logic bufWe;
    logic commit;
  } palStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } palState_t;

endpackage

// File: rtl/palListCtrl.sv
module palListCtrl
  import palPkg::*;
#(
  parameter int NUM_COLOURS = 16,
  parameter int ADDR_W      = 16,
  parameter int LINE_W      = 9,
  localparam int IDX_W      = $clog2(NUM_COLOURS),
  localparam int CNT_W      = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tgtWrite,
  input  logic [ADDR_W-1:0] listBase,
  input  logic [CNT_W-1:0]  listLen,
  input  logic [LINE_W-1:0] targetLine,
  input  logic              lineStart,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              memAck,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output palStrobes_t       strobes,
  output logic [IDX_W-1:0]  bufIdx,
  output logic [CNT_W-1:0]  commitCnt,
  output logic              listPending
);

  palState_t         state;
  logic [CNT_W-1:0]  fetchIdx;
  logic [CNT_W-1:0]  lenQ;
  logic [ADDR_W-1:0] baseQ;
  logic              lineHit;

  assign lineHit = lineStart && (lineNum == targetLine);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fetchIdx <= '0;
      lenQ     <= '0;
      baseQ    <= '0;
    end else if (tgtWrite) begin
      baseQ    <= listBase;
      lenQ     <= listLen;
      fetchIdx <= '0;
      state    <= (listLen == '0) ? ST_WAIT : ST_FETCH;
    end else begin
      unique case (state)
        ST_FETCH: if (memAck) begin
          fetchIdx <= fetchIdx + CNT_W'(1);
          if (fetchIdx + CNT_W'(1) == lenQ) state <= ST_WAIT;
        end
        ST_WAIT: if (lineHit) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memReq         = (state == ST_FETCH);
  assign memAddr        = baseQ + ADDR_W'(fetchIdx);
  assign bufIdx         = fetchIdx[IDX_W-1:0];
  assign commitCnt      = lenQ;
  assign listPending    = (state != ST_IDLE);
  assign strobes.bufWe  = (state == ST_FETCH) && memAck && !tgtWrite;
  assign strobes.commit = (state == ST_WAIT) && lineHit && !tgtWrite;

endmodule

// File: rtl/palListDatapath.sv
module palListDatapath
  import palPkg::*;
#(
  parameter int NUM_COLOURS = 16,
  parameter int COLOUR_W    = 8,
  parameter int ADDR_W      = 16,
  parameter int LINE_W      = 9,
  localparam int IDX_W      = $clog2(NUM_COLOURS),
  localparam int CNT_W      = IDX_W + 1,
  localparam int REG_AW     = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [ADDR_W-1:0]   regWrData,
  input  logic [COLOUR_W-1:0] memData,
  input  palStrobes_t         strobes,
  input  logic [IDX_W-1:0]    bufIdx,
  input  logic [CNT_W-1:0]    commitCnt,
  input  logic [IDX_W-1:0]    pixIdx,
  output logic [COLOUR_W-1:0] pixColour,
  output logic [ADDR_W-1:0]   listBase,
  output logic [CNT_W-1:0]    listLen,
  output logic [LINE_W-1:0]   targetLine,
  output logic                tgtWrite
);

  localparam logic [REG_AW-1:0] OFF_BASE = REG_AW'(NUM_COLOURS);
  localparam logic [REG_AW-1:0] OFF_LEN  = REG_AW'(NUM_COLOURS + 1);
  localparam logic [REG_AW-1:0] OFF_TGT  = REG_AW'(NUM_COLOURS + 2);

  logic [COLOUR_W-1:0] palette [NUM_COLOURS];
  logic [COLOUR_W-1:0] bufQ    [NUM_COLOURS];
  logic                colourWe;

  assign colourWe = regWrEn && !regAddr[REG_AW-1];
  assign tgtWrite = regWrEn && (regAddr == OFF_TGT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      listBase   <= '0;
      listLen    <= '0;
      targetLine <= '0;
    end else if (regWrEn) begin
      if (regAddr == OFF_BASE) listBase <= regWrData;
      if (regAddr == OFF_LEN)
        listLen <= (regWrData > ADDR_W'(NUM_COLOURS)) ? CNT_W'(NUM_COLOURS)
                                                       : regWrData[CNT_W-1:0];
      if (regAddr == OFF_TGT) targetLine <= regWrData[LINE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_COLOURS; i++) bufQ[i] <= '0;
    end else if (strobes.bufWe) begin
      bufQ[bufIdx] <= memData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_COLOURS; i++) palette[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_COLOURS; i++) begin
        if (strobes.commit && (CNT_W'(i) < commitCnt))
          palette[i] <= bufQ[i];
        else if (colourWe && (regAddr[IDX_W-1:0] == IDX_W'(i)))
          palette[i] <= regWrData[COLOUR_W-1:0];
      end
    end
  end

  assign pixColour = palette[pixIdx];

endmodule

// File: rtl/palListLoader.sv
module palListLoader
  import palPkg::*;
#(
  parameter int NUM_COLOURS = 16,
  parameter int COLOUR_W    = 8,
  parameter int ADDR_W      = 16,
  parameter int LINE_W      = 9,
  localparam int IDX_W      = $clog2(NUM_COLOURS),
  localparam int CNT_W      = IDX_W + 1,
  localparam int REG_AW     = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [ADDR_W-1:0]   regWrData,
  input  logic                lineStart,
  input  logic [LINE_W-1:0]   lineNum,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic                memAck,
  input  logic [COLOUR_W-1:0] memData,
  input  logic [IDX_W-1:0]    pixIdx,
  output logic [COLOUR_W-1:0] pixColour,
  output logic                listPending
);

  palStrobes_t       strobes;
  logic [IDX_W-1:0]  bufIdx;
  logic [CNT_W-1:0]  commitCnt;
  logic [ADDR_W-1:0] listBase;
  logic [CNT_W-1:0]  listLen;
  logic [LINE_W-1:0] targetLine;
  logic              tgtWrite;

  palListCtrl #(
    .NUM_COLOURS(NUM_COLOURS), .ADDR_W(ADDR_W), .LINE_W(LINE_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .tgtWrite(tgtWrite), .listBase(listBase),
    .listLen(listLen), .targetLine(targetLine), .lineStart(lineStart),
    .lineNum(lineNum), .memAck(memAck), .memReq(memReq), .memAddr(memAddr),
    .strobes(strobes), .bufIdx(bufIdx), .commitCnt(commitCnt),
    .listPending(listPending)
  );

  palListDatapath #(
    .NUM_COLOURS(NUM_COLOURS), .COLOUR_W(COLOUR_W), .ADDR_W(ADDR_W),
    .LINE_W(LINE_W)
  ) uData (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .memData(memData), .strobes(strobes),
    .bufIdx(bufIdx), .commitCnt(commitCnt), .pixIdx(pixIdx),
    .pixColour(pixColour), .listBase(listBase), .listLen(listLen),
    .targetLine(targetLine), .tgtWrite(tgtWrite)
  );

endmodule

// File: rtl/palListChecker.sv
module palListChecker #(
  parameter int NUM_COLOURS = 16,
  parameter int COLOUR_W    = 8,
  parameter int ADDR_W      = 16,
  parameter int LINE_W      = 9,
  localparam int IDX_W      = $clog2(NUM_COLOURS),
  localparam int REG_AW     = IDX_W + 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [REG_AW-1:0]   regAddr,
  input logic                lineStart,
  input logic                memReq,
  input logic [ADDR_W-1:0]   memAddr,
  input logic                memAck,
  input logic [IDX_W-1:0]    pixIdx,
  input logic [COLOUR_W-1:0] pixColour,
  input logic                listPending
);

  localparam logic [REG_AW-1:0] OFF_TGT = REG_AW'(NUM_COLOURS + 2);

  logic tgtWr;
  assign tgtWr = regWrEn && (regAddr == OFF_TGT);

  assert_arm_R3: assert property (@(posedge clk) disable iff (!rstN)
    tgtWr |=> listPending);

  assert_rise_only_on_arm_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(listPending) |-> $past(tgtWr));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !tgtWr) |=> (memReq && $stable(memAddr)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !tgtWr) |=> (!memReq || memAddr == $past(memAddr) + ADDR_W'(1)));

  assert_palette_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(pixIdx) && $past(!lineStart && !regWrEn)) |-> $stable(pixColour));

  assert_clear_on_line_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(listPending) |-> $past(lineStart));

  assert_req_needs_pending_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> listPending);

endmodule

bind palListLoader palListChecker #(
  .NUM_COLOURS(NUM_COLOURS), .COLOUR_W(COLOUR_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)
) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .lineStart(lineStart), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
  .pixIdx(pixIdx), .pixColour(pixColour), .listPending(listPending)
);

// File: tb/tb_palListLoader.sv
module tb_palListLoader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic        lineStart = 1'b0;
  logic [8:0]  lineNum = '0;
  logic        memReq;
  logic [15:0] memAddr;
  logic        memAck = 1'b0;
  logic [7:0]  memData = '0;
  logic [3:0]  pixIdx = '0;
  logic [7:0]  pixColour;
  logic        listPending;

  int          testsRun = 0;
  int          testsFailed = 0;
  int          ackCount = 0;
  int          addrErrs = 0;
  logic [15:0] expBase = '0;
  logic        ackEnable = 1'b1;
  logic        finished = 1'b0;

  always #5 clk = ~clk;

  palListLoader dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .lineStart(lineStart), .lineNum(lineNum),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .pixIdx(pixIdx), .pixColour(pixColour), .listPending(listPending)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // memory model: acknowledges every other cycle while enabled
  initial begin
    forever begin
      @(negedge clk);
      if (ackEnable && memReq && !memAck) begin
        memAck  = 1'b1;
        memData = memByte(memAddr);
        if (memAddr != expBase + 16'(ackCount)) addrErrs++;
        ackCount++;
      end else begin
        memAck = 1'b0;
      end
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic checkPix(input string req, input int idx, input int expected);
    pixIdx = 4'(idx);
    #1;
    check(req, int'(pixColour), expected);
  endtask

  task automatic regWrite(input int addr, input int data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 5'(addr); regWrData = 16'(data);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseLine(input int n);
    @(negedge clk);
    lineStart = 1'b1; lineNum = 9'(n);
    @(negedge clk);
    lineStart = 1'b0;
  endtask

  task automatic waitFetch();
    for (int k = 0; k < 200 && memReq; k++) @(negedge clk);
  endtask

  task automatic armList(input int base, input int len, input int line);
    expBase = 16'(base); ackCount = 0; addrErrs = 0;
    regWrite(16, base);
    regWrite(17, len);
    regWrite(18, line);
  endtask

  task automatic testReset();
    check("R1 pending", int'(listPending), 0);
    check("R1 memReq", int'(memReq), 0);
    for (int i = 0; i < 16; i++) checkPix("R1 entry", i, 0);
  endtask

  task automatic testDirect();
    regWrite(3, 16'h00A5);
    checkPix("R2 low bank", 3, 8'hA5);
    regWrite(12, 16'hFF3C);
    checkPix("R2 high bank", 12, 8'h3C);
    checkPix("R2 untouched", 0, 0);
  endtask

  task automatic testBasicList();
    armList(16'h1200, 4, 100);
    check("R3 armed", int'(listPending), 1);
    waitFetch();
    check("R4 read count", ackCount, 4);
    check("R4 address order", addrErrs, 0);
    checkPix("R6 not before line", 0, 0);
    pulseLine(99);
    checkPix("R6 other line", 0, 0);
    check("R6 still pending", int'(listPending), 1);
    pulseLine(100);
    for (int i = 0; i < 4; i++) checkPix("R7 applied", i, memByte(16'h1200 + 16'(i)));
    checkPix("R7 rest kept", 12, 8'h3C);
    check("R7 pending cleared", int'(listPending), 0);
  endtask

  task automatic testClip();
    armList(16'h2000, 40, 7);
    waitFetch();
    check("R5 clipped reads", ackCount, 16);
    check("R5 address order", addrErrs, 0);
    pulseLine(7);
    checkPix("R5 last entry", 15, memByte(16'h200F));
    checkPix("R5 mid entry", 12, memByte(16'h200C));
  endtask

  task automatic testZero();
    armList(16'h5000, 0, 20);
    check("R10 pending", int'(listPending), 1);
    repeat (4) @(negedge clk);
    check("R10 no request", int'(memReq), 0);
    check("R10 no reads", ackCount, 0);
    pulseLine(20);
    check("R10 cleared", int'(listPending), 0);
    checkPix("R10 unchanged", 0, memByte(16'h2000));
  endtask

  task automatic testLate();
    ackEnable = 1'b0;
    armList(16'h3040, 2, 30);
    repeat (3) @(negedge clk);
    pulseLine(30);
    check("R8 still pending", int'(listPending), 1);
    checkPix("R8 not applied", 0, memByte(16'h2000));
    ackEnable = 1'b1;
    waitFetch();
    pulseLine(30);
    checkPix("R8 later entry0", 0, memByte(16'h3040));
    checkPix("R8 later entry1", 1, memByte(16'h3041));
    check("R8 cleared", int'(listPending), 0);
  endtask

  task automatic testCancel();
    ackEnable = 1'b0;
    armList(16'h4000, 3, 50);
    repeat (3) @(negedge clk);
    regWrite(16, 16'h4080);
    regWrite(18, 60);
    expBase = 16'h4080; ackCount = 0; addrErrs = 0;
    ackEnable = 1'b1;
    waitFetch();
    check("R9 restart reads", ackCount, 3);
    check("R9 restart base", addrErrs, 0);
    pulseLine(50);
    check("R9 old line ignored", int'(listPending), 1);
    checkPix("R9 old not applied", 0, memByte(16'h3040));
    pulseLine(60);
    for (int i = 0; i < 3; i++) checkPix("R9 new list", i, memByte(16'h4080 + 16'(i)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirect();
    testBasicList();
    testClip();
    testZero();
    testLate();
    testCancel();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule